// File: doc/BRIEF.md
# Command Stream Validator

The block sits between an untrusted client and the writer that fills a command ring. The client submits a buffer as a stream of 32-bit dwords together with the buffer's total dword count. The block reads the header dword of each instruction and works out from its nested opcode fields how many dwords the instruction occupies. It then forwards the header and its payload unchanged to the ring side. A header that decodes to zero length is illegal. A header whose length would run past the end of the submitted buffer is rejected.

A submission is announced with a one-cycle `start` pulse that carries `total_cnt`. The submission is refused as a whole if the count is too large for the ring. When the submission was accepted and the count is odd, a single zero dword is emitted after the last dword, so that the ring always advances by an even number of dwords.

On any error the block stops forwarding and raises a sticky `err`. It keeps accepting the rest of the buffer and discards it. In every case the block ends the submission with a one-cycle `done` pulse.

Top module: `cmd_stream_check`

## Requirements
- R1: When header bits 31:29 are 0, the header is legal only if bits 28:23 equal 0 (no-op) or 4 (flush). Both are one dword long. Every other value of bits 28:23 is illegal.
- R2: A header with bits 31:29 equal to 1, 4, 5, 6 or 7 is illegal.
- R3: When bits 31:29 are 2, the instruction length is bits 7:0 plus 2.
- R4: When bits 31:29 are 3, opcode bits 28:24 at or below 0x18, or equal to 0x1C, give a length of 1. Opcodes 0x19, 0x1A and 0x1B are illegal.
- R5: For bits 31:29 equal to 3 and opcode 0x1D, bits 23:16 select the length. A value of 3 gives bits 4:0 plus 2. A value of 4 gives bits 3:0 plus 2. Any other value gives bits 15:0 plus 2.
- R6: For bits 31:29 equal to 3 and opcode 0x1E, the length is bits 15:0 plus 1 when bit 23 is set, and 1 when it is clear.
- R7: For bits 31:29 equal to 3 and opcode 0x1F, the length depends on bits 23 and 17:
  - Bit 23 clear: the length is bits 16:0 plus 2.
  - Bit 23 set, bit 17 clear: the length is 2.
  - Both bits set: the length is (bits 15:0 plus 1) divided by 2, rounded down, plus 1. The header is illegal if bits 15:0 are zero.
- R8: A header whose decoded length, added to the dwords already consumed, exceeds `total_cnt` is rejected. No dword of that instruction is forwarded.
- R9: A submission with (`total_cnt` + 1) × 4 ≥ `RING_BYTES` − 8 is rejected at start. With the default of 4096 bytes, a count of 1021 is rejected and 1020 is accepted. All of its dwords are drained and none is output.
- R10: After an accepted submission with an odd count, exactly one zero dword is output after the last input dword.
- R11: After an error, `err` stays high until the next start and no dword is output. The remaining input dwords are accepted and discarded.
- R12: `done` pulses high for one cycle after each submission completes, including a count of zero. `err` is low after reset and is cleared by `start`.
- R13: Every legal dword is output unchanged and in order, in the same cycle it is accepted, with one output per input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a submission; sampled only while idle |
| total_cnt | input | CNT_W | Dword count of the submission, captured with start |
| in_valid | input | 1 | Input dword valid |
| in_data | input | 32 | Input dword |
| in_ready | output | 1 | Input dword accepted when high with in_valid |
| out_valid | output | 1 | Output dword valid |
| out_data | output | 32 | Output dword |
| out_ready | input | 1 | Ring writer can take a dword |
| done | output | 1 | One-cycle pulse at the end of a submission |
| err | output | 1 | Sticky rejection flag, cleared by start |

## Verification
A wrong decoded length leaves the header/payload boundary misplaced. Because every following dword is then read as the wrong kind, the fault shows at the ports within the same submission, as a changed output count, a spurious `err`, or a missing or extra pad dword at `done`. A fault in the consumed-dword counter shows as an overrun that is missed or raised falsely at the header that crosses the end. It can also show as `done` coming early or late relative to the last input handshake. The near-exhaustive sweep over header top bytes, selector bytes and low fields makes each decode path change the output count directly.

// File: rtl/cmd_check_pkg.sv
package cmd_check_pkg;

  localparam int LEN_W = 18;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_PAY,
    S_PAD,
    S_DRAIN,
    S_FIN
  } seq_state_t;

  // Instruction length in dwords; zero marks an illegal header.
  function automatic logic [LEN_W-1:0] hdr_len(input logic [31:0] h);
    logic [LEN_W-1:0] n;
    n = '0;
    case (h[31:29])
      3'd0: if (h[28:23] == 6'd0 || h[28:23] == 6'd4) n = LEN_W'(1);
      3'd2: n = LEN_W'(h[7:0]) + LEN_W'(2);
      3'd3: begin
        if (h[28:24] <= 5'h18 || h[28:24] == 5'h1C) begin
          n = LEN_W'(1);
        end else if (h[28:24] == 5'h1D) begin
          case (h[23:16])
            8'd3:    n = LEN_W'(h[4:0]) + LEN_W'(2);
            8'd4:    n = LEN_W'(h[3:0]) + LEN_W'(2);
            default: n = LEN_W'(h[15:0]) + LEN_W'(2);
          endcase
        end else if (h[28:24] == 5'h1E) begin
          n = h[23] ? LEN_W'(h[15:0]) + LEN_W'(1) : LEN_W'(1);
        end else if (h[28:24] == 5'h1F) begin
          if (!h[23])               n = LEN_W'(h[16:0]) + LEN_W'(2);
          else if (!h[17])          n = LEN_W'(2);
          else if (h[15:0] != 16'd0) n = ((LEN_W'(h[15:0]) + LEN_W'(1)) >> 1) + LEN_W'(1);
        end
      end
      default: n = '0;
    endcase
    return n;
  endfunction

  // True when a submission of cnt dwords leaves room in the ring.
  function automatic logic fits_ring(input logic [31:0] cnt, input int unsigned ring_bytes);
    logic [63:0] need;
    need = ({32'd0, cnt} + 64'd1) << 2;
    return need < (64'(ring_bytes) - 64'd8);
  endfunction

endpackage

// File: rtl/cmd_len_decode.sv
module cmd_len_decode
  import cmd_check_pkg::*;
(
  input  logic [31:0]      hdr,
  output logic [LEN_W-1:0] len,
  output logic             legal
);
  assign len   = hdr_len(hdr);
  assign legal = (len != '0);
endmodule

// File: rtl/cmd_budget_check.sv
module cmd_budget_check
  import cmd_check_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RING_BYTES = 4096
) (
  input  logic [CNT_W-1:0] cnt,
  output logic             ok
);
  assign ok = fits_ring(32'(cnt), RING_BYTES);
endmodule

// File: rtl/cmd_stream_check.sv
module cmd_stream_check
  import cmd_check_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RING_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total_cnt,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  input  logic             out_ready,
  output logic             done,
  output logic             err
);
  localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1;

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic [LEN_W-1:0] rem_q;
  logic             err_q;

  logic [LEN_W-1:0] dec_len;
  logic             dec_legal, budget_ok;

  cmd_len_decode u_dec (.hdr(in_data), .len(dec_len), .legal(dec_legal));

  cmd_budget_check #(.CNT_W(CNT_W), .RING_BYTES(RING_BYTES)) u_budget (
    .cnt(total_cnt), .ok(budget_ok)
  );

  // Named events for the checker.
  logic hdr_fits, hdr_ok, last_in;
  logic hdr_take, hdr_bad, pay_take, drain_take;
  logic pad_cycle, drain_cycle;

  assign hdr_fits    = (SUM_W'(idx_q) + SUM_W'(dec_len)) <= SUM_W'(cnt_q);
  assign hdr_ok      = dec_legal && hdr_fits;
  assign last_in     = (SUM_W'(idx_q) + SUM_W'(1)) == SUM_W'(cnt_q);
  assign hdr_take    = (state_q == S_HDR) && in_valid && hdr_ok && out_ready;
  assign hdr_bad     = (state_q == S_HDR) && in_valid && !hdr_ok;
  assign pay_take    = (state_q == S_PAY) && in_valid && out_ready;
  assign drain_take  = (state_q == S_DRAIN) && in_valid;
  assign pad_cycle   = (state_q == S_PAD);
  assign drain_cycle = (state_q == S_DRAIN);

  always_comb begin
    in_ready = 1'b0;
    case (state_q)
      S_HDR:   in_ready = hdr_ok ? out_ready : 1'b1;
      S_PAY:   in_ready = out_ready;
      S_DRAIN: in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  assign out_valid = ((state_q == S_HDR) && in_valid && hdr_ok) ||
                     ((state_q == S_PAY) && in_valid) || pad_cycle;
  assign out_data  = pad_cycle ? 32'd0 : in_data;
  assign done      = (state_q == S_FIN);
  assign err       = err_q;

  seq_state_t tail_state;
  assign tail_state = cnt_q[0] ? S_PAD : S_FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          cnt_q <= total_cnt;
          idx_q <= '0;
          err_q <= !budget_ok;
          if (total_cnt == '0)  state_q <= S_FIN;
          else if (!budget_ok)  state_q <= S_DRAIN;
          else                  state_q <= S_HDR;
        end
        S_HDR: begin
          if (hdr_take) begin
            idx_q <= idx_q + 1'b1;
            rem_q <= dec_len - LEN_W'(1);
            if (dec_len != LEN_W'(1)) state_q <= S_PAY;
            else if (last_in)         state_q <= tail_state;
          end else if (hdr_bad) begin
            idx_q   <= idx_q + 1'b1;
            err_q   <= 1'b1;
            state_q <= last_in ? S_FIN : S_DRAIN;
          end
        end
        S_PAY: if (pay_take) begin
          idx_q <= idx_q + 1'b1;
          rem_q <= rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1)) state_q <= last_in ? tail_state : S_HDR;
        end
        S_DRAIN: begin
          if (idx_q == cnt_q) state_q <= S_FIN;
          else if (drain_take) begin
            idx_q <= idx_q + 1'b1;
            if (last_in) state_q <= S_FIN;
          end
        end
        S_PAD:   if (out_ready) state_q <= S_FIN;
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_stream_check_sva.sv
module cmd_stream_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        done,
  input logic        err,
  input logic        hdr_bad,
  input logic        pad_cycle,
  input logic        drain_cycle
);
  // R11: no output once a submission has failed
  a_r11_silent_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  // R11: flag holds until the next start
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  // R8: rejected header raises the flag on the next cycle
  a_r8_bad_hdr_flags: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad |=> err);

  // R11: draining consumes without emitting
  a_r11_drain_discards: assert property (@(posedge clk) disable iff (!rst_n)
    drain_cycle |-> (in_ready && !out_valid));

  // R10: the pad dword is zero
  a_r10_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pad_cycle |-> (out_valid && out_data == 32'd0));

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13: each forwarded input leaves unchanged in the same cycle
  a_r13_lossless: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !drain_cycle && !hdr_bad) |->
      (out_valid && out_ready && out_data == in_data));
endmodule

bind cmd_stream_check cmd_stream_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start(start),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .done(done), .err(err),
  .hdr_bad(hdr_bad), .pad_cycle(pad_cycle), .drain_cycle(drain_cycle)
);

// File: tb/cmd_stream_check_test.sv
module cmd_stream_check_test;
  localparam int CNT_W = 16;
  localparam int MAXB  = 1100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] total_cnt = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, done, err;
  logic [31:0] out_data;

  cmd_stream_check uut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_cnt(total_cnt),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done), .err(err)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0, n_out = 0;
  logic [31:0] stim [0:MAXB-1];
  logic [31:0] outs [0:MAXB-1];
  bit done_seen, err_at_done, err_after_start, bp_en;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      if (n_out < MAXB) outs[n_out] = out_data;
      n_out++;
    end
    if (done) begin done_seen = 1; err_at_done = err; end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL all: watchdog expired, actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(int count);
    n_out = 0; done_seen = 0;
    @(posedge clk); #1; start = 1; total_cnt = CNT_W'(count);
    @(posedge clk); #1; start = 0; err_after_start = err;
    for (int i = 0; i < count; i++) begin
      in_valid = 1; in_data = stim[i];
      forever begin @(negedge clk); if (in_ready) break; end
      @(posedge clk); #1;
    end
    in_valid = 0;
    while (!done_seen) @(negedge clk);
  endtask

  // Bench restatement of the length rules.
  function automatic int exp_len(logic [31:0] h);
    int c, op, lo;
    c = int'(h >> 29); op = int'((h >> 24) & 32'h1f); lo = int'(h & 32'hffff);
    if (c == 0) return (((h >> 23) & 32'h3f) == 0 || ((h >> 23) & 32'h3f) == 4) ? 1 : 0;
    if (c == 2) return int'(h & 32'hff) + 2;
    if (c != 3) return 0;
    if (op == 29) begin
      if (((h >> 16) & 32'hff) == 3) return int'(h & 32'h1f) + 2;
      if (((h >> 16) & 32'hff) == 4) return int'(h & 32'hf) + 2;
      return lo + 2;
    end
    if (op == 30) return h[23] ? lo + 1 : 1;
    if (op == 31) begin
      if (!h[23]) return int'(h & 32'h1ffff) + 2;
      if (!h[17]) return 2;
      if (lo == 0) return 0;
      return (lo + 1) / 2 + 1;
    end
    if (op >= 25 && op <= 27) return 0;
    return 1;
  endfunction

  function automatic string tag_of(logic [31:0] h);
    int c, op;
    c = int'(h >> 29); op = int'((h >> 24) & 32'h1f);
    if (c == 0) return "R1";
    if (c == 2) return "R3";
    if (c != 3) return "R2";
    if (op == 29) return "R5";
    if (op == 30) return "R6";
    if (op == 31) return "R7";
    return "R4";
  endfunction

  initial begin
    logic [7:0]  mids [5] = '{8'h00, 8'h03, 8'h04, 8'h80, 8'h82};
    logic [15:0] lows [3] = '{16'h0000, 16'h0005, 16'h0012};
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check(!out_valid && !in_ready && !done && !err, "R12", "reset outputs",
          {out_valid, in_ready, done, err}, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // R12: empty submission
    run(0);
    check(n_out == 0 && !err_at_done, "R12", "zero count", n_out, 0);

    // R10: odd count of no-ops gets one zero pad dword
    for (int i = 0; i < 3; i++) stim[i] = 32'h0;
    stim[1] = 32'h0200_0000;   // flush
    run(3);
    check(n_out == 4, "R10", "odd count output length", n_out, 4);
    check(outs[3] == 0 && outs[1] == 32'h0200_0000, "R10", "pad value", outs[3], 0);

    // R8: 2D header of length 5 in a 3-dword buffer
    stim[0] = 32'h4000_0003; stim[1] = 1; stim[2] = 2;
    run(3);
    check(n_out == 0, "R8", "overrun output count", n_out, 0);
    check(err_at_done, "R8", "overrun flag", err_at_done, 1);

    // R11: legal no-op forwarded, then bad header, rest drained
    stim[0] = 32'h0; stim[1] = 32'h2000_0000; stim[2] = 32'h0; stim[3] = 32'h0;
    run(4);
    check(n_out == 1 && outs[0] == 0, "R11", "output before error", n_out, 1);
    check(err_at_done, "R11", "flag at done", err_at_done, 1);
    repeat (5) @(negedge clk);
    check(err && !out_valid, "R11", "flag held while idle", err, 1);

    // R12: start clears the flag
    stim[0] = 32'h0; stim[1] = 32'h0;
    run(2);
    check(!err_after_start, "R12", "flag cleared by start", err_after_start, 0);
    check(n_out == 2 && !err_at_done, "R12", "clean run after error", n_out, 2);

    // R9: ring budget boundary
    for (int i = 0; i < 1021; i++) stim[i] = 32'h0;
    run(1021);
    check(n_out == 0 && err_at_done, "R9", "count 1021 rejected", n_out, 0);
    run(1020);
    check(n_out == 1020 && !err_at_done, "R9", "count 1020 accepted", n_out, 1020);

    // R1..R8, R13: sweep of header fields, backpressure on odd top bytes
    for (int t = 0; t < 256; t++) begin
      bp_en = t[0];
      foreach (mids[m]) foreach (lows[l]) begin
        logic [31:0] h;
        int L, cnt, expn;
        bit bad, data_ok;
        string tg;
        h = {t[7:0], mids[m], lows[l]};
        L = exp_len(h);
        tg = tag_of(h);
        stim[0] = h;
        if (L == 0)        begin cnt = 2; bad = 1; end
        else if (L > 100)  begin cnt = 4; bad = 1; tg = "R8"; end
        else               begin cnt = L; bad = 0; end
        for (int k = 1; k < cnt; k++) stim[k] = 32'hC0DE_0000 + k;
        run(cnt);
        expn = bad ? 0 : cnt + (cnt % 2);
        check(n_out == expn, tg, $sformatf("length of %h", h), n_out, expn);
        check(err_at_done == bad, tg, $sformatf("flag for %h", h), err_at_done, bad);
        data_ok = 1;
        if (!bad && n_out == expn) begin
          for (int k = 0; k < cnt; k++) if (outs[k] != stim[k]) data_ok = 0;
          if (cnt % 2 == 1 && outs[cnt] != 0) data_ok = 0;
        end
        check(data_ok, "R13", $sformatf("payload order for %h", h), data_ok, 1);
      end
    end
    bp_en = 0;

    summary();
    $finish;
  end
endmodule